// File: doc/BRIEF.md
# Prescaled 8-bit Pulse-Width Modulator

This block drives one pulse-width modulated output pin from a single 32-bit control word. The word is loaded through a plain write port: a one-cycle strobe together with the data. It carries a run bit, a 13-bit clock divisor, an 8-bit high-time threshold and a bit that forces the output high for the whole period.

A prescaler produces one tick every divisor-plus-one input clocks. Each tick advances an 8-bit step counter, so a period is always 256 steps long. The output goes high when the step counter returns to zero. It goes low once the counter reaches the threshold, unless the force bit is set.

Any write restarts the prescaler and the step counter, so new settings take effect on the clock after the write. If the write clears the run bit, the output falls low on that same clock, wherever the period happens to be.

Top module: `pwm_top`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge) the output is 0 from that edge on. It stays 0 until a write sets the run bit.
- R2: Control word layout: bit 31 is run, bit 24 is force-full, bits 23:16 are the threshold and bits 12:0 are the divisor. All other bits have no effect on the output.
- R3: While running with unchanged settings, the output pattern repeats every 256 × (divisor + 1) clocks. Each period starts high unless the threshold is 0 and force-full is clear.
- R4: With force-full clear, the output is high for exactly threshold × (divisor + 1) clocks at the start of each period and low for the rest.
- R5: A threshold of 0 with force-full clear keeps the output low for the whole period.
- R6: With force-full set, the output stays high for the whole period whatever the threshold holds.
- R7: A write with run clear drives the output to 0 from the clock after the write, at any point of the period. The output stays 0 while run stays clear.
- R8: A write with run set aborts the current period. The new period starts on the clock after the write, with the prescaler and step counter at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Write strobe for the control word |
| wrData | input | 32 | Control word written when `wrEn` is high |
| pwmOut | output | 1 | Modulated output, high is active |

## Verification
The control word is stored at the clock edge that sees `wrEn`. The output then reflects the new settings, including the forced low of a cleared run bit, on the sample taken just after that same edge, so there is one clock of latency from write to output. After that, output sample k in the period equals (k < threshold × (divisor + 1)), and sample 256 × (divisor + 1) falls at the start of the next period. The bench samples one nanosecond after each rising edge and counts samples from the write edge. Every check therefore lands on the exact cycle in which the result is due.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  // Control word geometry; positions are decoded by the control module.
  parameter int CTRL_W    = 32;
  parameter int RUN_BIT   = 31;
  parameter int FULL_BIT  = 24;
  parameter int THR_LSB   = 16;
  parameter int THR_W     = 8;
  parameter int DIV_LSB   = 0;
  parameter int DIV_W     = 13;

  // Strobes from the control side to the counting datapath.
  typedef struct packed {
    logic restart;  // a write happened this cycle
    logic tick;     // prescaler terminal count while running
    logic run;      // run bit currently set
  } pwmStrobe_t;

endpackage

// File: rtl/pwm_ctrl.sv
module pwm_ctrl
  import pwm_pkg::*;
#(
  parameter int DataW  = CTRL_W,
  parameter int ScaleW = DIV_W,
  parameter int DutyW  = THR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [DataW-1:0]  wrData,
  output pwmStrobe_t        strobe,
  output logic [DutyW-1:0]  dutyVal,
  output logic              fullDuty
);

  localparam logic [DataW-1:0] RunMask  = DataW'(1) << RUN_BIT;
  localparam logic [DataW-1:0] FullMask = DataW'(1) << FULL_BIT;
  localparam logic [DataW-1:0] DutyMask = ((DataW'(1) << DutyW) - DataW'(1)) << THR_LSB;
  localparam logic [DataW-1:0] DivMask  = ((DataW'(1) << ScaleW) - DataW'(1)) << DIV_LSB;
  localparam logic [DataW-1:0] UsedMask = RunMask | FullMask | DutyMask | DivMask;

  logic              runReg;
  logic [ScaleW-1:0] scaleReg;
  logic [ScaleW-1:0] preCnt;
  logic              preTerm;
  logic              unusedReserved;

  // Reserved bits are dropped on write.
  assign unusedReserved = ^(wrData & ~UsedMask);

  always_ff @(posedge clk) begin
    if (rst) begin
      runReg   <= 1'b0;
      fullDuty <= 1'b0;
      dutyVal  <= '0;
      scaleReg <= '0;
    end else if (wrEn) begin
      runReg   <= wrData[RUN_BIT];
      fullDuty <= wrData[FULL_BIT];
      dutyVal  <= wrData[THR_LSB +: DutyW];
      scaleReg <= wrData[DIV_LSB +: ScaleW];
    end
  end

  assign preTerm = (preCnt == scaleReg);

  // Prescaler: terminal count every scaleReg+1 clocks, cleared by any write.
  always_ff @(posedge clk) begin
    if (rst || wrEn || !runReg) begin
      preCnt <= '0;
    end else if (preTerm) begin
      preCnt <= '0;
    end else begin
      preCnt <= preCnt + ScaleW'(1);
    end
  end

  always_comb begin
    strobe.restart = wrEn;
    strobe.run     = runReg;
    strobe.tick    = runReg && preTerm && !wrEn;
  end

endmodule

// File: rtl/pwm_dp.sv
module pwm_dp
  import pwm_pkg::*;
#(
  parameter int DutyW = THR_W
) (
  input  logic             clk,
  input  logic             rst,
  input  pwmStrobe_t       strobe,
  input  logic [DutyW-1:0] dutyVal,
  input  logic             fullDuty,
  output logic             pwmOut
);

  logic [DutyW-1:0] stepCnt;

  // Step counter wraps naturally after 2**DutyW steps.
  always_ff @(posedge clk) begin
    if (rst || strobe.restart || !strobe.run) begin
      stepCnt <= '0;
    end else if (strobe.tick) begin
      stepCnt <= stepCnt + DutyW'(1);
    end
  end

  assign pwmOut = strobe.run && (fullDuty || (stepCnt < dutyVal));

endmodule

// File: rtl/pwm_top.sv
module pwm_top
  import pwm_pkg::*;
#(
  parameter int DataW  = CTRL_W,
  parameter int ScaleW = DIV_W,
  parameter int DutyW  = THR_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrEn,
  input  logic [DataW-1:0] wrData,
  output logic             pwmOut
);

  pwmStrobe_t       strobe;
  logic [DutyW-1:0] dutyVal;
  logic             fullDuty;

  pwm_ctrl #(.DataW(DataW), .ScaleW(ScaleW), .DutyW(DutyW)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .wrEn     (wrEn),
    .wrData   (wrData),
    .strobe   (strobe),
    .dutyVal  (dutyVal),
    .fullDuty (fullDuty)
  );

  pwm_dp #(.DutyW(DutyW)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .dutyVal  (dutyVal),
    .fullDuty (fullDuty),
    .pwmOut   (pwmOut)
  );

endmodule

// File: rtl/pwm_top_checker.sv
module pwm_top_checker
  import pwm_pkg::*;
#(
  parameter int DataW = CTRL_W,
  parameter int DutyW = THR_W
) (
  input logic             clk,
  input logic             rst,
  input logic             wrEn,
  input logic [DataW-1:0] wrData,
  input logic             pwmOut
);

  // Port-level shadow of the last written mode.
  logic shRun, shFull, shZero;

  always_ff @(posedge clk) begin
    if (rst) begin
      shRun  <= 1'b0;
      shFull <= 1'b0;
      shZero <= 1'b0;
    end else if (wrEn) begin
      shRun  <= wrData[RUN_BIT];
      shFull <= wrData[RUN_BIT] && wrData[FULL_BIT];
      shZero <= wrData[RUN_BIT] && !wrData[FULL_BIT] &&
                (wrData[THR_LSB +: DutyW] == '0);
    end
  end

  p_reset_low_r1: assert property (@(posedge clk) rst |=> !pwmOut);

  p_stop_low_r7: assert property (@(posedge clk) disable iff (rst)
    (wrEn && !wrData[RUN_BIT]) |=> !pwmOut);

  p_idle_low_r7: assert property (@(posedge clk) disable iff (rst)
    !shRun |-> !pwmOut);

  p_restart_high_r8: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrData[RUN_BIT] &&
     (wrData[FULL_BIT] || (wrData[THR_LSB +: DutyW] != '0))) |=> pwmOut);

  p_full_high_r6: assert property (@(posedge clk) disable iff (rst)
    shFull |-> pwmOut);

  p_zero_low_r5: assert property (@(posedge clk) disable iff (rst)
    shZero |-> !pwmOut);

endmodule

bind pwm_top pwm_top_checker #(.DataW(DataW), .DutyW(DutyW)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .wrEn   (wrEn),
  .wrData (wrData),
  .pwmOut (pwmOut)
);

// File: tb/pwm_top_bench.sv
`timescale 1ns/1ps
module pwm_top_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic        pwmOut;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;   // 200 MHz

  pwm_top u_pwm_top (
    .clk    (clk),
    .rst    (rst),
    .wrEn   (wrEn),
    .wrData (wrData),
    .pwmOut (pwmOut)
  );

  typedef struct packed {
    logic [12:0] scale;
    logic [7:0]  duty;
    logic        full;
    int          expHigh;
    int          expPeriod;
  } vec_t;

  // Expected high time = duty*(scale+1) (or full period); period = 256*(scale+1).
  localparam vec_t VECS [8] = '{
    '{13'd0,  8'd128, 1'b0, 128,  256},
    '{13'd1,  8'd64,  1'b0, 128,  512},
    '{13'd3,  8'd10,  1'b0, 40,   1024},
    '{13'd0,  8'd0,   1'b0, 0,    256},
    '{13'd2,  8'd255, 1'b0, 765,  768},
    '{13'd1,  8'd5,   1'b1, 512,  512},
    '{13'd0,  8'd255, 1'b0, 255,  256},
    '{13'd12, 8'd1,   1'b0, 13,   3328}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mkWord(input bit run, input bit full,
                                         input logic [7:0] duty, input logic [12:0] scale);
    return {run, 6'd0, full, duty, 3'd0, scale};
  endfunction

  // Write at a negedge; returns 1 ns after the capturing edge (sample index 0).
  task automatic writeReg(input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1;
    wrData = d;
    @(posedge clk);
    #1;
    wrEn = 1'b0;
    wrData = '0;
  endtask

  task automatic stepCycles(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  // Sample P cycles from index 0; count highs and mismatches against (i < expHigh).
  task automatic measure(input int p, input int expHigh, output int high, output int mism);
    high = 0;
    mism = 0;
    for (int i = 0; i < p; i++) begin
      if (pwmOut) high++;
      if (pwmOut != (i < expHigh)) mism++;
      @(posedge clk);
      #1;
    end
  endtask

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int high, mism, lowSeen;
    stepCycles(3);
    check(pwmOut == 1'b0, "R1 reset output", pwmOut, 0);
    rst = 1'b0;
    stepCycles(20);
    check(pwmOut == 1'b0, "R1 idle after reset", pwmOut, 0);

    // Table walk: R3 period, R4 high time, R5 zero duty, R6 force-full.
    foreach (VECS[k]) begin
      writeReg(mkWord(1'b1, VECS[k].full, VECS[k].duty, VECS[k].scale));
      measure(VECS[k].expPeriod, VECS[k].expHigh, high, mism);
      check(high == VECS[k].expHigh, "R4/R5/R6 high time", high, VECS[k].expHigh);
      check(mism == 0, "R4 high at period start", mism, 0);
      check(pwmOut == (VECS[k].expHigh != 0), "R3 next period start",
            pwmOut, int'(VECS[k].expHigh != 0));
      stepCycles(VECS[k].expHigh == 0 ? 1 : 0);
    end

    // R3: second full period matches the first.
    writeReg(mkWord(1'b1, 1'b0, 8'd30, 13'd1));
    measure(512, 60, high, mism);
    measure(512, 60, high, mism);
    check(high == 60 && mism == 0, "R3 repeated period", high, 60);

    // R2: reserved bits set change nothing.
    writeReg(mkWord(1'b1, 1'b0, 8'd40, 13'd1) | 32'h7E00_E000);
    measure(512, 80, high, mism);
    check(high == 80 && mism == 0, "R2 reserved bits ignored", high, 80);

    // R6: force-full ignores duty 0.
    writeReg(mkWord(1'b1, 1'b1, 8'd0, 13'd0));
    measure(256, 256, high, mism);
    check(high == 256, "R6 full with zero duty", high, 256);

    // R7: disable mid high phase.
    writeReg(mkWord(1'b1, 1'b0, 8'd200, 13'd0));
    stepCycles(50);
    check(pwmOut == 1'b1, "R7 high before stop", pwmOut, 1);
    writeReg(mkWord(1'b0, 1'b0, 8'd200, 13'd0));
    check(pwmOut == 1'b0, "R7 low after stop", pwmOut, 0);
    measure(300, 0, high, mism);
    check(high == 0, "R7 stays low", high, 0);

    // R7: a stop write with full and duty set still forces low.
    writeReg(mkWord(1'b1, 1'b1, 8'd0, 13'd2));
    stepCycles(5);
    writeReg(mkWord(1'b0, 1'b1, 8'd99, 13'd2));
    lowSeen = pwmOut;
    check(lowSeen == 0, "R7 stop overrides force-full", lowSeen, 0);

    // R8: rewrite in low phase restarts period.
    writeReg(mkWord(1'b1, 1'b0, 8'd100, 13'd0));
    stepCycles(150);
    check(pwmOut == 1'b0, "R8 low phase before rewrite", pwmOut, 0);
    writeReg(mkWord(1'b1, 1'b0, 8'd100, 13'd0));
    measure(256, 100, high, mism);
    check(high == 100 && mism == 0, "R8 restarted period", high, 100);

    // R8: rewrite mid-prescale with new divisor.
    writeReg(mkWord(1'b1, 1'b0, 8'd3, 13'd7));
    stepCycles(13);
    writeReg(mkWord(1'b1, 1'b0, 8'd4, 13'd2));
    measure(768, 12, high, mism);
    check(high == 12 && mism == 0, "R8 new divisor from zero", high, 12);

    // R1: reset while running.
    writeReg(mkWord(1'b1, 1'b1, 8'd0, 13'd0));
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    check(pwmOut == 1'b0, "R1 reset while running", pwmOut, 0);
    @(negedge clk);
    rst = 1'b0;
    measure(40, 0, high, mism);
    check(high == 0, "R1 low until written", high, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule